// File: doc/BRIEF.md
# XGMII Link Fault Signaling Controller

This block sits beside a 10 Gb/s reconciliation layer. It inspects every 32-bit receive column together with its four per-lane control bits and picks out the two fault sequence ordered sets: local fault and remote fault. It keeps a debounced link-fault status of OK, local fault or remote fault. That status is shown to client logic as a 2-bit code. The same status also steers the transmit column toward the PHY.

A fault is declared only when the same fault sequence has been seen more than three times inside a 128-column window. A sequence of the other type restarts that count. A declared fault clears after 128 consecutive columns that carry no fault sequence.

While a local fault is declared, every transmit column is replaced with the remote-fault sequence. While a remote fault is declared, idle columns are sent in place of client traffic. With the link OK, the client column passes straight through in the same cycle.

The design is a pipeline of four pieces. A column decoder feeds a counting state machine with the states CS_IDLE, CS_LOCAL and CS_REMOTE. The counting machine feeds a status state machine with the states LS_OK, LS_LOCAL and LS_REMOTE. The status machine controls a transmit selector.

The counting machine moves as follows:
- CS_IDLE goes to CS_LOCAL or CS_REMOTE on the first sequence of that type.
- A counting state restarts in the other counting state on a sequence of the other type.
- A counting state returns to CS_IDLE when its window expires with no sequence.
- A counting state returns to CS_IDLE when it emits a declaration.

The status machine moves as follows:
- Any state goes to LS_LOCAL or LS_REMOTE on a declaration of that type.
- LS_LOCAL and LS_REMOTE return to LS_OK when the quiet count completes.

Top module: `xgmii_fault_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the status to OK and clears every count, so that the transmit path passes client columns through after reset.
- R2: A column is a fault sequence only when all of the following hold. The control bits are 4'b0001. Lane 0 (bits [7:0]) holds 0x9C. Lanes 1 and 2 (bits [23:8]) are zero. Lane 3 (bits [31:24]) holds 0x01 for a local fault or 0x02 for a remote fault. Any other column, such as 0x9C outside lane 0, wrong control bits or another lane-3 code, counts as no sequence.
- R3: A fault of a given type is declared in the cycle after the fourth sequence of that type. That fourth sequence must arrive no later than column 127, counting the first sequence of the window as column 0.
- R4: Three sequences of one type with nothing further do not change the status.
- R5: A sequence of the other type discards the running count and starts a new window with a count of one for the new type.
- R6: The status output encodes OK as 2'b00, local fault as 2'b01 and remote fault as 2'b10. The value 2'b11 never appears.
- R7: A declared fault returns to OK after 128 consecutive columns with no fault sequence. A sequence of either type restarts that quiet count.
- R8: While the status is local fault, the transmit output is 0x0200009C with control 4'b0001 in every cycle.
- R9: While the status is remote fault, the transmit output is 0x07070707 with control 4'hF in every cycle.
- R10: While the status is OK, the transmit data and control equal the client inputs in the same cycle.
- R11: While one fault is declared, four sequences of the other type within a window switch the status directly to that other fault.
- R12: A sequence that arrives at column 128 or later of a window does not add to the old count. It opens a new window with a count of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 32 | Receive column, lane 0 in bits [7:0] |
| rx_ctrl | input | 4 | Receive control bit per lane, 1 marks a control character |
| cl_tx_data | input | 32 | Client transmit column |
| cl_tx_ctrl | input | 4 | Client transmit control bits |
| tx_data | output | 32 | Transmit column toward the PHY |
| tx_ctrl | output | 4 | Transmit control bits toward the PHY |
| fault_status | output | 2 | Link fault code: 00 OK, 01 local, 10 remote |

## Verification
Directed columns that differ from a fault sequence in one field show that only the exact lane-0 start with the right lane-3 code is counted. Sequence trains are spaced so that the fourth arrival falls on column 127 or on column 128, which pins down the window edge. Further trains mix the two types to show that the count restarts, and quiet runs of 127 and 128 columns pin down the release point. Long random stretches then alternate quiet spells, sparse sequences and dense mixed bursts. These stretches are checked cycle by cycle against a bench model of status and transmit output, which separates errors in counting, in releasing and in the transmit selection.

// File: rtl/xgmii_lfs_pkg.sv
package xgmii_lfs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int COL_W  = LANES * LANE_W;

    localparam logic [7:0] CH_SEQ      = 8'h9C;
    localparam logic [7:0] CH_IDLE     = 8'h07;
    localparam logic [7:0] CODE_LOCAL  = 8'h01;
    localparam logic [7:0] CODE_REMOTE = 8'h02;

    typedef enum logic [1:0] {
        SEQ_NONE   = 2'b00,
        SEQ_LOCAL  = 2'b01,
        SEQ_REMOTE = 2'b10
    } seq_kind_e;

    typedef enum logic [1:0] {
        LS_OK     = 2'b00,
        LS_LOCAL  = 2'b01,
        LS_REMOTE = 2'b10
    } link_state_e;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'b00,
        CS_LOCAL  = 2'b01,
        CS_REMOTE = 2'b10
    } cnt_state_e;

endpackage

// File: rtl/xgmii_lfs_detect.sv
module xgmii_lfs_detect
    import xgmii_lfs_pkg::*;
(
    input  logic [COL_W-1:0] col_data,
    input  logic [LANES-1:0] col_ctrl,
    output seq_kind_e        kind
);

    localparam int MID = LANES - 2;

    logic           lead_ok;
    logic [MID-1:0] mid_ok;
    logic [7:0]     code;

    assign lead_ok = col_ctrl[0] && (col_data[LANE_W-1:0] == CH_SEQ);
    assign code    = col_data[(LANES-1)*LANE_W +: LANE_W];

    genvar i;
    generate
        for (i = 1; i <= MID; i++) begin : g_mid
            assign mid_ok[i-1] = !col_ctrl[i] && (col_data[i*LANE_W +: LANE_W] == '0);
        end
    endgenerate

    always_comb begin
        kind = SEQ_NONE;
        if (lead_ok && (&mid_ok) && !col_ctrl[LANES-1]) begin
            if (code == CODE_LOCAL) begin
                kind = SEQ_LOCAL;
            end else if (code == CODE_REMOTE) begin
                kind = SEQ_REMOTE;
            end
        end
    end

endmodule

// File: rtl/xgmii_lfs_counter.sv
module xgmii_lfs_counter
    import xgmii_lfs_pkg::*;
#(
    parameter int WINDOW = 128,
    parameter int THRESH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  seq_kind_e kind,
    output logic      decl_vld,
    output seq_kind_e decl_kind
);

    localparam int CW = $clog2(WINDOW + 1);
    localparam int NW = $clog2(THRESH + 2);

    cnt_state_e    st_q, st_d;
    logic [CW-1:0] col_q, col_d, col_idx;
    logic [NW-1:0] num_q, num_d;
    logic          hit_same;

    function automatic cnt_state_e start_of(seq_kind_e k);
        return (k == SEQ_LOCAL) ? CS_LOCAL : CS_REMOTE;
    endfunction

    assign col_idx  = col_q + CW'(1);
    assign hit_same = ((st_q == CS_LOCAL)  && (kind == SEQ_LOCAL)) ||
                      ((st_q == CS_REMOTE) && (kind == SEQ_REMOTE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_IDLE;
            col_q <= '0;
            num_q <= '0;
        end else begin
            st_q  <= st_d;
            col_q <= col_d;
            num_q <= num_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        col_d     = col_q;
        num_d     = num_q;
        decl_vld  = 1'b0;
        decl_kind = SEQ_NONE;
        unique case (st_q)
            CS_IDLE: begin
                if (kind != SEQ_NONE) begin
                    st_d  = start_of(kind);
                    col_d = '0;
                    num_d = NW'(1);
                end
            end
            CS_LOCAL, CS_REMOTE: begin
                if (col_idx >= CW'(WINDOW)) begin
                    if (kind != SEQ_NONE) begin
                        st_d  = start_of(kind);
                        col_d = '0;
                        num_d = NW'(1);
                    end else begin
                        st_d  = CS_IDLE;
                        col_d = '0;
                        num_d = '0;
                    end
                end else if (hit_same) begin
                    if (num_q == NW'(THRESH)) begin
                        decl_vld  = 1'b1;
                        decl_kind = kind;
                        st_d      = CS_IDLE;
                        col_d     = '0;
                        num_d     = '0;
                    end else begin
                        num_d = num_q + NW'(1);
                        col_d = col_idx;
                    end
                end else if (kind != SEQ_NONE) begin
                    st_d  = start_of(kind);
                    col_d = '0;
                    num_d = NW'(1);
                end else begin
                    col_d = col_idx;
                end
            end
            default: begin
                st_d  = CS_IDLE;
                col_d = '0;
                num_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/xgmii_lfs_status.sv
module xgmii_lfs_status
    import xgmii_lfs_pkg::*;
#(
    parameter int QUIET = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  seq_kind_e   kind,
    input  logic        decl_vld,
    input  seq_kind_e   decl_kind,
    output link_state_e link_st
);

    localparam int QW = $clog2(QUIET + 2);

    link_state_e   st_q, st_d;
    logic [QW-1:0] quiet_q, quiet_d, quiet_inc;

    assign quiet_inc = quiet_q + QW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LS_OK;
            quiet_q <= '0;
        end else begin
            st_q    <= st_d;
            quiet_q <= quiet_d;
        end
    end

    always_comb begin
        if (kind != SEQ_NONE) begin
            quiet_d = '0;
        end else if (quiet_q == QW'(QUIET)) begin
            quiet_d = quiet_q;
        end else begin
            quiet_d = quiet_inc;
        end

        st_d = st_q;
        if (decl_vld) begin
            st_d = (decl_kind == SEQ_LOCAL) ? LS_LOCAL : LS_REMOTE;
        end else begin
            unique case (st_q)
                LS_OK: st_d = LS_OK;
                LS_LOCAL, LS_REMOTE: begin
                    if ((kind == SEQ_NONE) && (quiet_inc == QW'(QUIET))) begin
                        st_d = LS_OK;
                    end
                end
                default: st_d = LS_OK;
            endcase
        end
    end

    assign link_st = st_q;

endmodule

// File: rtl/xgmii_lfs_txsel.sv
module xgmii_lfs_txsel
    import xgmii_lfs_pkg::*;
(
    input  link_state_e      link_st,
    input  logic [COL_W-1:0] cl_data,
    input  logic [LANES-1:0] cl_ctrl,
    output logic [COL_W-1:0] out_data,
    output logic [LANES-1:0] out_ctrl
);

    logic [COL_W-1:0] rf_col;
    logic [COL_W-1:0] idle_col;
    logic [LANES-1:0] rf_ctrl;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            if (i == 0) begin : g_first
                assign rf_col[i*LANE_W +: LANE_W] = CH_SEQ;
                assign rf_ctrl[i]                 = 1'b1;
            end else if (i == LANES - 1) begin : g_last
                assign rf_col[i*LANE_W +: LANE_W] = CODE_REMOTE;
                assign rf_ctrl[i]                 = 1'b0;
            end else begin : g_mid
                assign rf_col[i*LANE_W +: LANE_W] = '0;
                assign rf_ctrl[i]                 = 1'b0;
            end
            assign idle_col[i*LANE_W +: LANE_W] = CH_IDLE;
        end
    endgenerate

    always_comb begin
        unique case (link_st)
            LS_LOCAL: begin
                out_data = rf_col;
                out_ctrl = rf_ctrl;
            end
            LS_REMOTE: begin
                out_data = idle_col;
                out_ctrl = '1;
            end
            default: begin
                out_data = cl_data;
                out_ctrl = cl_ctrl;
            end
        endcase
    end

endmodule

// File: rtl/xgmii_fault_ctrl.sv
module xgmii_fault_ctrl
    import xgmii_lfs_pkg::*;
#(
    parameter int WINDOW = 128,
    parameter int THRESH = 3,
    parameter int QUIET  = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] rx_data,
    input  logic [3:0]  rx_ctrl,
    input  logic [31:0] cl_tx_data,
    input  logic [3:0]  cl_tx_ctrl,
    output logic [31:0] tx_data,
    output logic [3:0]  tx_ctrl,
    output logic [1:0]  fault_status
);

    seq_kind_e   seq_kind;
    logic        decl_vld;
    seq_kind_e   decl_kind;
    link_state_e link_st;

    xgmii_lfs_detect u_detect (
        .col_data (rx_data),
        .col_ctrl (rx_ctrl),
        .kind     (seq_kind)
    );

    xgmii_lfs_counter #(
        .WINDOW (WINDOW),
        .THRESH (THRESH)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .kind      (seq_kind),
        .decl_vld  (decl_vld),
        .decl_kind (decl_kind)
    );

    xgmii_lfs_status #(
        .QUIET (QUIET)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .kind      (seq_kind),
        .decl_vld  (decl_vld),
        .decl_kind (decl_kind),
        .link_st   (link_st)
    );

    xgmii_lfs_txsel u_txsel (
        .link_st  (link_st),
        .cl_data  (cl_tx_data),
        .cl_ctrl  (cl_tx_ctrl),
        .out_data (tx_data),
        .out_ctrl (tx_ctrl)
    );

    assign fault_status = link_st;

endmodule

// File: rtl/xgmii_fault_ctrl_chk.sv
module xgmii_fault_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cl_tx_data,
    input logic [3:0]  cl_tx_ctrl,
    input logic [31:0] tx_data,
    input logic [3:0]  tx_ctrl,
    input logic [1:0]  fault_status,
    input logic [1:0]  seq_kind
);

    localparam logic [1:0] K_NONE   = 2'b00;
    localparam logic [1:0] K_LOCAL  = 2'b01;
    localparam logic [1:0] K_REMOTE = 2'b10;

    p_status_code_r6: assert property (@(posedge clk) disable iff (rst)
        fault_status != 2'b11)
        else $error("p_status_code_r6");

    p_local_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (fault_status == K_LOCAL && $past(fault_status) != K_LOCAL) |-> $past(seq_kind) == K_LOCAL)
        else $error("p_local_entry_r3");

    p_remote_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (fault_status == K_REMOTE && $past(fault_status) != K_REMOTE) |-> $past(seq_kind) == K_REMOTE)
        else $error("p_remote_entry_r3");

    p_release_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_status == K_NONE && $past(fault_status) != K_NONE) |-> $past(seq_kind) == K_NONE)
        else $error("p_release_quiet_r7");

    p_hold_on_seq_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_status != K_NONE && seq_kind != K_NONE) |=> fault_status != K_NONE)
        else $error("p_hold_on_seq_r7");

    p_remote_col_r8: assert property (@(posedge clk) disable iff (rst)
        fault_status == K_LOCAL |-> (tx_data == 32'h0200009C && tx_ctrl == 4'b0001))
        else $error("p_remote_col_r8");

    p_idle_col_r9: assert property (@(posedge clk) disable iff (rst)
        fault_status == K_REMOTE |-> (tx_data == 32'h07070707 && tx_ctrl == 4'hF))
        else $error("p_idle_col_r9");

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        fault_status == K_NONE |-> (tx_data == cl_tx_data && tx_ctrl == cl_tx_ctrl))
        else $error("p_passthru_r10");

endmodule

bind xgmii_fault_ctrl xgmii_fault_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cl_tx_data   (cl_tx_data),
    .cl_tx_ctrl   (cl_tx_ctrl),
    .tx_data      (tx_data),
    .tx_ctrl      (tx_ctrl),
    .fault_status (fault_status),
    .seq_kind     (seq_kind)
);

// File: tb/xgmii_fault_ctrl_tb.sv
module xgmii_fault_ctrl_tb;

    localparam logic [31:0] LF_W   = 32'h0100009C;
    localparam logic [31:0] RF_W   = 32'h0200009C;
    localparam logic [31:0] IDLE_W = 32'h07070707;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctrl = '0;
    logic [31:0] cl_tx_data = '0;
    logic [3:0]  cl_tx_ctrl = '0;
    logic [31:0] tx_data;
    logic [3:0]  tx_ctrl;
    logic [1:0]  fault_status;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int         m_type, m_cnt, m_col, m_quiet;
    logic [1:0] m_stat;

    always #5 clk = ~clk;

    xgmii_fault_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .rx_data      (rx_data),
        .rx_ctrl      (rx_ctrl),
        .cl_tx_data   (cl_tx_data),
        .cl_tx_ctrl   (cl_tx_ctrl),
        .tx_data      (tx_data),
        .tx_ctrl      (tx_ctrl),
        .fault_status (fault_status)
    );

    function automatic int kind_of(logic [31:0] d, logic [3:0] c);
        if (c == 4'b0001 && d == LF_W) return 1;
        if (c == 4'b0001 && d == RF_W) return 2;
        return 0;
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_type = 0; m_cnt = 0; m_col = 0; m_quiet = 0; m_stat = 2'b00;
    endtask

    task automatic model_upd(int k);
        int dec;
        int idx;
        dec = 0;
        if (m_type == 0) begin
            if (k != 0) begin m_type = k; m_cnt = 1; m_col = 0; end
        end else begin
            idx = m_col + 1;
            if (idx >= 128) begin
                if (k != 0) begin m_type = k; m_cnt = 1; m_col = 0; end
                else begin m_type = 0; m_cnt = 0; m_col = 0; end
            end else if (k == m_type) begin
                m_cnt++;
                m_col = idx;
                if (m_cnt > 3) begin dec = k; m_type = 0; m_cnt = 0; m_col = 0; end
            end else if (k != 0) begin
                m_type = k; m_cnt = 1; m_col = 0;
            end else begin
                m_col = idx;
            end
        end
        if (dec != 0) m_stat = dec[1:0];
        else if (k == 0 && m_stat != 2'b00 && m_quiet + 1 == 128) m_stat = 2'b00;
        if (k != 0) m_quiet = 0;
        else if (m_quiet < 128) m_quiet++;
    endtask

    function automatic logic [35:0] exp_tx(logic [31:0] cd, logic [3:0] cc);
        if (m_stat == 2'b01) return {4'b0001, RF_W};
        if (m_stat == 2'b10) return {4'hF, IDLE_W};
        return {cc, cd};
    endfunction

    // one column: drive, check against model, clock it, update model
    task automatic step(logic [31:0] rd, logic [3:0] rc);
        @(negedge clk);
        rx_data    = rd;
        rx_ctrl    = rc;
        cl_tx_data = $urandom;
        cl_tx_ctrl = 4'($urandom);
        #1;
        check("R6 status vs model", {34'd0, fault_status}, {34'd0, m_stat});
        check(m_stat == 2'b01 ? "R8 tx" : (m_stat == 2'b10 ? "R9 tx" : "R10 tx"),
              {tx_ctrl, tx_data}, exp_tx(cl_tx_data, cl_tx_ctrl));
        @(posedge clk);
        model_upd(kind_of(rd, rc));
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step(IDLE_W, 4'hF);
    endtask

    task automatic lseq(); step(LF_W, 4'b0001); endtask
    task automatic rseq(); step(RF_W, 4'b0001); endtask

    task automatic peek(string tag, logic [1:0] exp);
        #2;
        check(tag, {34'd0, fault_status}, {34'd0, exp});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        cl_tx_data = 32'h11223344;
        cl_tx_ctrl = 4'b0010;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state and pass-through
        check("R1 status after reset", {34'd0, fault_status}, 36'd0);
        check("R1 tx after reset", {tx_ctrl, tx_data}, {4'b0010, 32'h11223344});

        // R2: near-miss columns never count
        for (int r = 0; r < 2; r++) begin
            step(LF_W, 4'b0011);
            step(32'h01009C00, 4'b0010);
            step(LF_W, 4'b0000);
            step(32'h0300009C, 4'b0001);
            step(32'h0101009C, 4'b0001);
        end
        peek("R2 lookalikes ignored", 2'b00);

        // R4: three sequences only
        lseq(); lseq(); lseq();
        peek("R4 three sequences", 2'b00);
        quiet(130);

        // R3 / R8: fourth local sequence declares
        lseq(); lseq(); lseq(); lseq();
        peek("R3 local declared", 2'b01);
        #1;
        check("R8 remote column sent", {tx_ctrl, tx_data}, {4'b0001, RF_W});

        // R7: release after 128 quiet columns
        quiet(127);
        peek("R7 held at 127", 2'b01);
        quiet(1);
        peek("R7 released at 128", 2'b00);

        // R7: any sequence restarts the quiet count
        lseq(); lseq(); lseq(); lseq();
        quiet(100);
        rseq();
        quiet(127);
        peek("R7 quiet restarted by sequence", 2'b01);
        quiet(1);
        peek("R7 released after restart", 2'b00);

        // R5: other type restarts the count
        lseq(); lseq(); lseq(); rseq(); rseq(); rseq();
        peek("R5 mixed types no fault", 2'b00);
        rseq();
        peek("R5 remote declared", 2'b10);
        #1;
        check("R9 idle column sent", {tx_ctrl, tx_data}, {4'hF, IDLE_W});

        // R11: switch from remote to local
        lseq(); lseq(); lseq();
        peek("R11 still remote", 2'b10);
        lseq();
        peek("R11 switched to local", 2'b01);
        quiet(128);
        peek("R7 back to OK", 2'b00);

        // R3 boundary: fourth sequence at column 127
        lseq(); quiet(39); lseq(); quiet(39); lseq(); quiet(46); lseq();
        peek("R3 fourth at column 127", 2'b01);
        quiet(128);

        // R12: fourth sequence at column 128 opens a new window
        lseq(); quiet(39); lseq(); quiet(39); lseq(); quiet(47); lseq();
        peek("R12 column 128 not counted", 2'b00);
        lseq(); lseq();
        peek("R12 new window count three", 2'b00);
        lseq();
        peek("R12 new window declares", 2'b01);
        quiet(128);

        // R10: pass-through in OK
        step(32'hDEADBEEF, 4'b0100);
        #2;
        check("R10 pass-through", {tx_ctrl, tx_data}, {cl_tx_ctrl, cl_tx_data});

        // random segments
        for (int s = 0; s < 60; s++) begin
            int len;
            int mode;
            len  = 1 + int'($urandom % 150);
            mode = int'($urandom % 3);
            for (int i = 0; i < len; i++) begin
                int p;
                p = int'($urandom % 100);
                if ((mode == 1 && p < 3) || (mode == 2 && p < 45)) begin
                    if ($urandom % 3 == 0) rseq(); else lseq();
                end else if (p > 92) begin
                    step(($urandom % 2) ? LF_W : RF_W, 4'($urandom));
                end else if (p > 70) begin
                    step($urandom, 4'($urandom));
                end else begin
                    step(IDLE_W, 4'hF);
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule